// File: doc/BRIEF.md
# Flash Block Write Buffer Controller

This controller sits between the byte write port a CPU uses for external data and the programming interface of an on-chip non-volatile memory. When programming is enabled, each accepted byte write is turned into a programming request. The request is issued either for that byte alone or, in block mode, for a small aligned block that the controller assembles from several writes. When programming is not enabled, the same writes pass straight through to ordinary data RAM.

In block mode the block length depends on the target region. Code space uses four-byte blocks and the scratchpad region uses two-byte blocks. The bytes of a block must arrive in strictly ascending order. Programming starts only when the top byte of the block is written. A programming operation, whether for one byte or a whole block, keeps the controller busy for a fixed number of cycles. During that time the CPU port is stalled. A write that breaks the ordering throws away the partial block and raises a sticky error flag.

Top module: `flash_blk_wbuf`

## Requirements
- R1: While reset is held, and right after it, `busy`, `pgm_req`, `done` and `seq_err` are 0 and `wr_rdy` is 1.
- R2: A write is accepted when `wr_en` and `wr_rdy` are both 1. An accepted write goes to the memory array only if `prog_en` and `flash_we` are both 1. Otherwise, in the same cycle, `ram_we` is 1 and `ram_addr`/`ram_data` equal the write, and no programming request follows.
- R3: With `blk_mode`=0, an accepted array write makes `pgm_req` high for exactly the next cycle. At that point `pgm_addr` is the write address and `pgm_data[7:0]` is the byte, with bits 31:8 equal to 0xFFFFFF. `pgm_mask` is 4'b0001, and `pgm_scratch`/`pgm_bank` hold `scratch_sel`/`bank_sel`. The request outputs then stay stable while `busy` is high.
- R4: With `blk_mode`=1 and `scratch_sel`=0, a block is four bytes selected by address bits [1:0] = 0,1,2,3. Byte i appears in `pgm_data[8i+7:8i]`, `pgm_addr` has bits [1:0]=0, and `pgm_mask` is 4'b1111.
- R5: With `blk_mode`=1 and `scratch_sel`=1, a block is two bytes selected by address bit 0. `pgm_mask` is 4'b0011, `pgm_data[31:16]` is 0xFFFF, and `pgm_addr` bit 0 is 0.
- R6: In block mode, `pgm_req` rises only in the cycle after the write to the top byte of the block (index 3 in code space, 1 in scratchpad). Lower bytes are only buffered.
- R7: After a request-starting write, `busy` is high for exactly PROG_LAT cycles, beginning with the `pgm_req` cycle. `done` is high for one cycle, the first cycle in which `busy` is low again.
- R8: While `busy` is high, `wr_rdy` is 0 and a write held on the port is neither accepted nor passed to RAM.
- R9: In block mode, a write whose index differs from the next expected one, or whose block address, `scratch_sel` or `bank_sel` differs from the block being built, is ignored. The partial block is discarded and `seq_err` is set. `seq_err` stays set until a cycle with `prog_en`=0.
- R10: The partial block is discarded without an error when `prog_en` is 0 or `blk_mode` differs from its value in the previous cycle. The next block must then start at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU byte write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 8 | Write byte |
| wr_rdy | output | 1 | Write port ready; low stalls the CPU |
| prog_en | input | 1 | Steer writes to the memory array |
| flash_we | input | 1 | Global write/erase enable |
| blk_mode | input | 1 | 1 selects block programming |
| scratch_sel | input | 1 | Target the scratchpad region |
| bank_sel | input | 2 | Code bank for code-space writes |
| ram_we | output | 1 | Pass-through write to data RAM |
| ram_addr | output | ADDR_W | Data RAM address |
| ram_data | output | 8 | Data RAM byte |
| pgm_req | output | 1 | One-cycle programming request |
| pgm_addr | output | ADDR_W | Byte or block base address |
| pgm_data | output | 32 | Four byte lanes, untouched lanes 0xFF |
| pgm_mask | output | 4 | Byte lanes taking part |
| pgm_scratch | output | 1 | Request targets scratchpad |
| pgm_bank | output | 2 | Request code bank |
| busy | output | 1 | Programming in progress |
| done | output | 1 | One-cycle completion pulse |
| seq_err | output | 1 | Sticky block ordering error |

## Verification
The main function is driven with directed single-byte writes, a full four-byte code block, and a two-byte scratchpad block. Together these separate lane placement, mask width and the 0xFF fill of unused lanes. Broken sequences are then applied: a skipped index, a repeated index, and a bank switch in mid-block. Each must discard the buffer instead of merging stale bytes. A refilled block after a `blk_mode` toggle or a `prog_en` drop shows that the earlier bytes are gone. Random writes mostly follow the expected sequence, with occasional strays, control changes and stalled writes during busy. This mix exercises the ordering check against arbitrary interleavings of region, bank and gating.

// File: rtl/flash_blk_wbuf.sv
module flash_blk_wbuf #(
  parameter int ADDR_W   = 16,
  parameter int PROG_LAT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              wr_rdy,
  input  logic              prog_en,
  input  logic              flash_we,
  input  logic              blk_mode,
  input  logic              scratch_sel,
  input  logic [1:0]        bank_sel,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_data,
  output logic              pgm_req,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [31:0]       pgm_data,
  output logic [3:0]        pgm_mask,
  output logic              pgm_scratch,
  output logic [1:0]        pgm_bank,
  output logic              busy,
  output logic              done,
  output logic              seq_err
);

  localparam int CNT_W = $clog2(PROG_LAT + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [31:0]       buf_q;
  logic [1:0]        ptr_q;
  logic [ADDR_W-1:0] base_q;
  logic              bscr_q;
  logic [1:0]        bbank_q;
  logic              mode_q;

  logic              acc, to_flash, fl_acc, clr, in_seq, blk_ok, blk_bad, launch;
  logic [1:0]        idx, top_idx, cur_ptr;
  logic [ADDR_W-1:0] aligned;
  logic [31:0]       merged;

  assign busy     = (cnt_q != '0);
  assign wr_rdy   = !busy;
  assign acc      = wr_en && wr_rdy;
  assign to_flash = prog_en && flash_we;
  assign ram_we   = acc && !to_flash;
  assign ram_addr = wr_addr;
  assign ram_data = wr_data;
  assign fl_acc   = acc && to_flash;

  assign clr     = !prog_en || (blk_mode != mode_q);
  assign top_idx = scratch_sel ? 2'd1 : 2'd3;
  assign idx     = scratch_sel ? {1'b0, wr_addr[0]} : wr_addr[1:0];
  assign aligned = scratch_sel ? {wr_addr[ADDR_W-1:1], 1'b0} : {wr_addr[ADDR_W-1:2], 2'b00};
  assign cur_ptr = clr ? 2'd0 : ptr_q;

  assign in_seq  = (idx == cur_ptr) &&
                   ((cur_ptr == 2'd0) ||
                    (aligned == base_q && scratch_sel == bscr_q && bank_sel == bbank_q));
  assign blk_ok  = fl_acc && blk_mode && in_seq;
  assign blk_bad = fl_acc && blk_mode && !in_seq;
  assign launch  = fl_acc && (!blk_mode || (in_seq && idx == top_idx));

  always_comb begin
    merged = (cur_ptr == 2'd0) ? 32'hFFFF_FFFF : buf_q;
    merged[{idx, 3'b000} +: 8] = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      done    <= 1'b0;
      pgm_req <= 1'b0;
    end else begin
      pgm_req <= launch;
      done    <= (cnt_q == CNT_W'(1));
      if (launch)    cnt_q <= CNT_W'(PROG_LAT);
      else if (busy) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pgm_addr    <= '0;
      pgm_data    <= '1;
      pgm_mask    <= '0;
      pgm_scratch <= 1'b0;
      pgm_bank    <= '0;
    end else if (launch) begin
      pgm_addr    <= blk_mode ? aligned : wr_addr;
      pgm_data    <= blk_mode ? merged : {24'hFF_FFFF, wr_data};
      pgm_mask    <= !blk_mode ? 4'b0001 : (scratch_sel ? 4'b0011 : 4'b1111);
      pgm_scratch <= scratch_sel;
      pgm_bank    <= bank_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= '1;
      ptr_q   <= '0;
      base_q  <= '0;
      bscr_q  <= 1'b0;
      bbank_q <= '0;
      mode_q  <= 1'b0;
      seq_err <= 1'b0;
    end else begin
      mode_q <= blk_mode;
      if (blk_ok && !launch) begin
        buf_q   <= merged;
        ptr_q   <= cur_ptr + 2'd1;
        base_q  <= aligned;
        bscr_q  <= scratch_sel;
        bbank_q <= bank_sel;
      end else if (clr || blk_bad || launch) begin
        ptr_q <= '0;
      end
      if (!prog_en)     seq_err <= 1'b0;
      else if (blk_bad) seq_err <= 1'b1;
    end
  end

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |-> $past(prog_en && flash_we)); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pgm_req) |-> ($stable(pgm_data) && $stable(pgm_addr) && $stable(pgm_mask))); // R3
  AST_CODE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_req && $past(blk_mode) && !$past(scratch_sel)) |-> ($past(wr_addr[1:0]) == 2'b11)); // R6
  AST_SCR_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_req && $past(blk_mode) && $past(scratch_sel)) |-> $past(wr_addr[0])); // R5
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |=> (!pgm_req && (PROG_LAT < 2 || busy))); // R7
  AST_DONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!prog_en) |-> !seq_err); // R9

endmodule

// File: tb/sim_flash_blk_wbuf.sv
module sim_flash_blk_wbuf;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 16;
  localparam int LAT    = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, prog_en = 1'b0, flash_we = 1'b0, blk_mode = 1'b0, scratch_sel = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] bank_sel = '0;
  logic wr_rdy, ram_we, pgm_req, pgm_scratch, busy, done, seq_err;
  logic [ADDR_W-1:0] ram_addr, pgm_addr;
  logic [7:0] ram_data;
  logic [31:0] pgm_data;
  logic [3:0] pgm_mask;
  logic [1:0] pgm_bank;

  int n_chk = 0, n_bad = 0;

  logic [31:0]       m_buf;
  logic [1:0]        m_ptr;
  logic [ADDR_W-1:0] m_base;
  logic              m_scr;
  logic [1:0]        m_bank;
  logic              m_err;

  always #(CLK_P/2) clk = ~clk;

  flash_blk_wbuf #(.ADDR_W(ADDR_W), .PROG_LAT(LAT)) u0 (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .wr_rdy, .prog_en, .flash_we,
    .blk_mode, .scratch_sel, .bank_sel, .ram_we, .ram_addr, .ram_data,
    .pgm_req, .pgm_addr, .pgm_data, .pgm_mask, .pgm_scratch, .pgm_bank,
    .busy, .done, .seq_err);

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] align_of(input logic [ADDR_W-1:0] a, input logic scr);
    return scr ? (a & ~ADDR_W'(1)) : (a & ~ADDR_W'(3));
  endfunction

  function automatic logic [1:0] idx_of(input logic [ADDR_W-1:0] a, input logic scr);
    return scr ? {1'b0, a[0]} : a[1:0];
  endfunction

  task automatic wait_busy(input logic stall);
    for (int k = 1; k <= LAT + 1; k++) begin
      if (k <= LAT) chk(busy === 1'b1 && done === 1'b0, "R7 busy", {busy, done}, 2'b10);
      else          chk(busy === 1'b0 && done === 1'b1, "R7 done", {busy, done}, 2'b01);
      if (stall && k == 2) begin
        wr_en = 1'b1; wr_addr = ADDR_W'($urandom); wr_data = 8'($urandom);
        #1 chk(wr_rdy === 1'b0 && ram_we === 1'b0, "R8 stall", {wr_rdy, ram_we}, 2'b00);
      end
      if (k == 3) wr_en = 1'b0;
      if (k <= LAT) @(negedge clk);
    end
  endtask

  task automatic set_ctrl(input logic pe, input logic fwe, input logic bm, input logic sc, input logic [1:0] bk);
    if (!pe || bm != blk_mode) m_ptr = 2'd0;
    if (!pe) m_err = 1'b0;
    prog_en = pe; flash_we = fwe; blk_mode = bm; scratch_sel = sc; bank_sel = bk;
    @(negedge clk);
    chk(seq_err === m_err, "R9/R10 err after ctrl", seq_err, m_err);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d, input logic stall);
    logic to_fl, launch, ok;
    logic [1:0] idx, top;
    logic [31:0] ed;
    logic [3:0] em;
    logic [ADDR_W-1:0] ea;
    to_fl = prog_en && flash_we;
    launch = 1'b0; ed = '1; em = '0; ea = a;
    if (to_fl && !blk_mode) begin
      launch = 1'b1; ed = {24'hFF_FFFF, d}; em = 4'b0001;
    end else if (to_fl) begin
      idx = idx_of(a, scratch_sel);
      top = scratch_sel ? 2'd1 : 2'd3;
      ok = (idx == m_ptr) && (m_ptr == 2'd0 ||
           (align_of(a, scratch_sel) == m_base && scratch_sel == m_scr && bank_sel == m_bank));
      if (!ok) begin
        m_err = 1'b1; m_ptr = 2'd0;
      end else begin
        if (m_ptr == 2'd0) m_buf = '1;
        m_buf[{idx, 3'b000} +: 8] = d;
        m_base = align_of(a, scratch_sel); m_scr = scratch_sel; m_bank = bank_sel;
        if (idx == top) begin
          launch = 1'b1; ed = m_buf; ea = m_base; m_ptr = 2'd0;
          em = scratch_sel ? 4'b0011 : 4'b1111;
        end else m_ptr = m_ptr + 2'd1;
      end
    end
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1;
    chk(ram_we === !to_fl, "R2 ram_we", ram_we, !to_fl);
    if (!to_fl) chk(ram_addr === a && ram_data === d, "R2 ram path", {ram_addr, ram_data}, {a, d});
    @(negedge clk);
    wr_en = 1'b0;
    chk(pgm_req === launch, blk_mode ? "R6 req timing" : "R3 req", pgm_req, launch);
    chk(seq_err === m_err, "R9 seq_err", seq_err, m_err);
    if (launch && pgm_req) begin
      chk(pgm_addr === ea, "R3/R4 addr", pgm_addr, ea);
      chk(pgm_data === ed, scratch_sel ? "R5 data" : "R4 data", pgm_data, ed);
      chk(pgm_mask === em, "R3/R5 mask", pgm_mask, em);
      chk(pgm_scratch === scratch_sel && pgm_bank === bank_sel, "R3 region", {pgm_scratch, pgm_bank}, {scratch_sel, bank_sel});
      wait_busy(stall);
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0, "R7 idle", {busy, done}, 2'b00);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_buf = '1; m_ptr = '0; m_base = '0; m_scr = 0; m_bank = '0; m_err = 0;
    repeat (3) @(negedge clk);
    chk(busy === 0 && pgm_req === 0 && done === 0 && seq_err === 0 && wr_rdy === 1,
        "R1 reset", {busy, pgm_req, done, seq_err, wr_rdy}, 5'b00001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 0 && pgm_req === 0 && seq_err === 0 && wr_rdy === 1, "R1 after reset",
        {busy, pgm_req, seq_err, wr_rdy}, 4'b0001);

    // R2: gating
    set_ctrl(0, 1, 0, 0, 2'd0); wr(16'h0123, 8'h5A, 0);
    set_ctrl(1, 0, 0, 0, 2'd0); wr(16'h0124, 8'hA5, 0);
    // R3: single byte, with stall (R8)
    set_ctrl(1, 1, 0, 0, 2'd2); wr(16'h0457, 8'h3C, 1);
    set_ctrl(1, 1, 0, 1, 2'd0); wr(16'h0011, 8'h00, 0);
    // R4/R6: code block
    set_ctrl(1, 1, 1, 0, 2'd1);
    wr(16'h1000, 8'h11, 0); wr(16'h1001, 8'h22, 0); wr(16'h1002, 8'h33, 0); wr(16'h1003, 8'h44, 1);
    // R5: scratch block
    set_ctrl(1, 1, 1, 1, 2'd0);
    wr(16'h0040, 8'hC0, 0); wr(16'h0041, 8'hC1, 0);
    // R9: skipped index, then repeated index, then bank switch
    set_ctrl(1, 1, 1, 0, 2'd3);
    wr(16'h2000, 8'h01, 0); wr(16'h2002, 8'h03, 0);
    wr(16'h2001, 8'h02, 0);
    wr(16'h2000, 8'h10, 0); wr(16'h2000, 8'h10, 0);
    wr(16'h2000, 8'h20, 0); bank_sel = 2'd0; wr(16'h2001, 8'h21, 0);
    set_ctrl(0, 1, 1, 0, 2'd0);
    // R10: mode toggle discards partial block
    set_ctrl(1, 1, 1, 0, 2'd0);
    wr(16'h3000, 8'hAA, 0); wr(16'h3001, 8'hBB, 0);
    set_ctrl(1, 1, 0, 0, 2'd0); set_ctrl(1, 1, 1, 0, 2'd0);
    wr(16'h3002, 8'hCC, 0);
    set_ctrl(0, 1, 1, 0, 2'd0); set_ctrl(1, 1, 1, 0, 2'd0);
    wr(16'h3000, 8'h01, 0); wr(16'h3001, 8'h02, 0);
    set_ctrl(0, 1, 1, 0, 2'd0); set_ctrl(1, 1, 1, 0, 2'd0);
    wr(16'h3000, 8'h05, 0); wr(16'h3001, 8'h06, 0); wr(16'h3002, 8'h07, 0); wr(16'h3003, 8'h08, 0);

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      if ($urandom_range(0, 19) == 0)
        set_ctrl($urandom_range(0, 7) != 0, $urandom_range(0, 7) != 0, $urandom_range(0, 3) != 0,
                 1'($urandom), 2'($urandom));
      if ($urandom_range(0, 9) < 7 && m_ptr != 2'd0) a = m_base | ADDR_W'(m_ptr);
      else if ($urandom_range(0, 1) == 0) a = align_of(ADDR_W'($urandom), scratch_sel);
      else a = ADDR_W'($urandom);
      wr(a, 8'($urandom), $urandom_range(0, 3) == 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule